// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

This block is a register-mapped CRC accelerator. Software programs a seed and a 32-bit generator polynomial, then writes a control word. That control write reloads the running CRC from the seed and sets how bits are ordered on the way in and on the way out. After that, every 32-bit write to the data register folds one whole word into the running CRC in a single clock. A read of the same register returns the current value, mirrored or not as the control word selects.

The polynomial is a register, so one engine serves any 32-bit CRC variant. Two common uses are the Ethernet CRC-32 (generator 0x04C11DB7) and the Castagnoli CRC-32C (generator 0x1EDC6F41). Both run in reflected mode with an all-ones seed. In that mode the value read back is the reflected CRC before its final inversion, and software applies that inversion where the variant needs it.

The bus is a plain single-cycle register port: write enable, read enable, word address, write data and read data. It has no back-pressure. Every access completes in the cycle it is presented. Read data is combinational, and it is zero whenever the read enable is low.

Top module: `crc_regfile_engine`

## Requirements
- R1: After reset, the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data register reads 0xFFFFFFFF.
- R2: Word addresses are fixed. Data is at 0, control at 2, seed at 4 and polynomial at 5 (byte offsets 0x00, 0x08, 0x10, 0x14). The seed and polynomial registers read back the last value written.
- R3: Writing the control register with bit 0 set copies the seed into the running CRC, and the new value is visible on the next cycle. Bit 0 is not stored and always reads as 0.
- R4: Control bits 7:5 are stored and read back. All other control bits read as 0.
- R5: A data write updates the running CRC with the full word, processing it MSB first. Each of the 32 steps shifts the CRC left one place and XORs in the polynomial when (CRC bit 31 XOR data bit) is 1. The result is readable on the next cycle. When no data write and no reload occurs, the running CRC does not change.
- R6: When control bits 6:5 are nonzero, each data word is bit-reversed (bit i goes to bit 31-i) before it is folded in.
- R7: When control bit 7 is 1, a data-register read returns the running CRC bit-reversed.
- R8: With seed 0xFFFFFFFF, the correct normal polynomial and control 0xE1, words packed little-endian from a byte stream read back as the reflected byte-wise CRC state (no final XOR). This holds for both CRC-32 and CRC-32C.
- R9: Reading the data register has no side effect, so consecutive reads return the same value.
- R10: Writes to unmapped word addresses change no register. Reads from unmapped addresses return 0.
- R11: A data read and a data write in the same cycle return the value from before that write. The write still takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | CRC_W | Write data |
| bus_rdata | output | CRC_W | Read data, combinational, 0 when not reading |

## Verification
The data register can be folded into and read in the same cycle. The bench provokes this by raising both strobes together on address 0 with a fresh word. It judges the result by expecting the pre-update CRC on that cycle, then the post-update CRC on a plain read one cycle later. A control reload and a data write are the other pair that compete for the accumulator. Because they share one bus, they meet only on back-to-back cycles, and the bench checks that the reload value is seen before the first fold.

// File: rtl/crc_regs_pkg.sv
package crc_regs_pkg;
  localparam int unsigned WADDR_DATA = 0;
  localparam int unsigned WADDR_CTRL = 2;
  localparam int unsigned WADDR_SEED = 4;
  localparam int unsigned WADDR_POLY = 5;

  localparam int unsigned CTL_RELOAD  = 0;
  localparam int unsigned CTL_INREV_LO = 5;
  localparam int unsigned CTL_INREV_HI = 6;
  localparam int unsigned CTL_OUTREV  = 7;

  localparam logic [31:0] SEED_RST = 32'hFFFF_FFFF;
  localparam logic [31:0] POLY_RST = 32'h04C1_1DB7;
endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  logic [W-1:0] flipped;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped[i] = din[W-1-i];
  end

  assign dout = en ? flipped : din;
endmodule

// File: rtl/crc_word_step.sv
module crc_word_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] word,
  input  logic [W-1:0] poly,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] stage [0:W];

  assign stage[0] = crc_in;

  for (genvar s = 0; s < W; s++) begin : g_stage
    logic fb;
    assign fb = stage[s][W-1] ^ word[W-1-s];
    assign stage[s+1] = {stage[s][W-2:0], 1'b0} ^ (fb ? poly : '0);
  end

  assign crc_out = stage[W];
endmodule

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_regs_pkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CRC_W-1:0]  wdata,
  output logic [CRC_W-1:0]  seed_q,
  output logic [CRC_W-1:0]  poly_q,
  output logic [1:0]        in_rev_q,
  output logic              out_rev_q,
  output logic              reload
);
  logic hit_ctrl, hit_seed, hit_poly;

  assign hit_ctrl = wr && (addr == ADDR_W'(WADDR_CTRL));
  assign hit_seed = wr && (addr == ADDR_W'(WADDR_SEED));
  assign hit_poly = wr && (addr == ADDR_W'(WADDR_POLY));
  assign reload   = hit_ctrl && wdata[CTL_RELOAD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seed_q    <= CRC_W'(SEED_RST);
      poly_q    <= CRC_W'(POLY_RST);
      in_rev_q  <= 2'b00;
      out_rev_q <= 1'b0;
    end else begin
      if (hit_seed) seed_q <= wdata;
      if (hit_poly) poly_q <= wdata;
      if (hit_ctrl) begin
        in_rev_q  <= wdata[CTL_INREV_HI:CTL_INREV_LO];
        out_rev_q <= wdata[CTL_OUTREV];
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(seed_q) && $stable(poly_q))); // R10
endmodule

// File: rtl/crc_regfile_engine.sv
module crc_regfile_engine
  import crc_regs_pkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CRC_W-1:0]  bus_wdata,
  output logic [CRC_W-1:0]  bus_rdata
);
  logic [CRC_W-1:0] seed_q, poly_q, acc_q;
  logic [CRC_W-1:0] word_in, acc_next, acc_view, ctrl_view;
  logic [1:0]       in_rev_q;
  logic             out_rev_q, reload, data_wr;

  crc_cfg_regs #(.CRC_W(CRC_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .seed_q(seed_q), .poly_q(poly_q), .in_rev_q(in_rev_q),
    .out_rev_q(out_rev_q), .reload(reload)
  );

  bit_mirror #(.W(CRC_W)) u_in_flip (
    .din(bus_wdata), .en(|in_rev_q), .dout(word_in)
  );

  crc_word_step #(.W(CRC_W)) u_step (
    .crc_in(acc_q), .word(word_in), .poly(poly_q), .crc_out(acc_next)
  );

  bit_mirror #(.W(CRC_W)) u_out_flip (
    .din(acc_q), .en(out_rev_q), .dout(acc_view)
  );

  assign data_wr = bus_wr && (bus_addr == ADDR_W'(WADDR_DATA));

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= CRC_W'(SEED_RST);
    else if (reload)  acc_q <= seed_q;
    else if (data_wr) acc_q <= acc_next;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_INREV_HI:CTL_INREV_LO] = in_rev_q;
    ctrl_view[CTL_OUTREV] = out_rev_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(WADDR_DATA): bus_rdata = acc_view;
        ADDR_W'(WADDR_CTRL): bus_rdata = ctrl_view;
        ADDR_W'(WADDR_SEED): bus_rdata = seed_q;
        ADDR_W'(WADDR_POLY): bus_rdata = poly_q;
        default:             bus_rdata = '0;
      endcase
    end
  end

  AST_RELOAD_TAKES_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (acc_q == $past(seed_q))); // R3
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(acc_q)); // R9
  AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(WADDR_CTRL)) |->
      (bus_rdata[4:0] == 5'd0 && bus_rdata[CRC_W-1:8] == '0)); // R4
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/sim_crc_regfile_engine.sv
module sim_crc_regfile_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  crc_regfile_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] flip32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] fold_msb(input logic [31:0] c, input logic [31:0] w,
                                           input logic [31:0] p);
    for (int i = 31; i >= 0; i--) begin
      if (c[31] ^ w[i]) c = (c << 1) ^ p;
      else              c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] fold_byte_refl(input logic [31:0] c, input logic [7:0] b,
                                                 input logic [31:0] rp);
    c = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
    return c;
  endfunction

  // Monitor: pops expected values whenever a read is on the bus.
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        fails++; checks++;
        $display("FAIL scoreboard underflow actual=%08h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s actual=%08h expected=%08h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wr_rd(input logic [3:0] a, input logic [31:0] d,
                       input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = a; bus_wdata = d;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic refl_run(input logic [31:0] npoly, input logic [31:0] rpoly,
                          input string t);
    logic [7:0]  msg [12];
    logic [31:0] st;
    string       s;
    s = "123456789abc";
    for (int i = 0; i < 12; i++) msg[i] = s[i];
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd5, npoly);
    wr(4'd2, 32'h0000_00E1);
    st = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      wr(4'd0, {msg[4*k+3], msg[4*k+2], msg[4*k+1], msg[4*k]});
      for (int j = 0; j < 4; j++) st = fold_byte_refl(st, msg[4*k+j], rpoly);
    end
    rd(4'd0, st, t);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] acc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'd4, 32'hFFFF_FFFF, "R1 seed reset");
    rd(4'd5, 32'h04C1_1DB7, "R1 poly reset");
    rd(4'd2, 32'h0, "R1 ctrl reset");
    rd(4'd0, 32'hFFFF_FFFF, "R1 data reset");

    wr(4'd4, 32'h1234_5678);
    rd(4'd4, 32'h1234_5678, "R2 seed readback");
    wr(4'd5, 32'h1EDC_6F41);
    rd(4'd5, 32'h1EDC_6F41, "R2 poly readback");

    wr(4'd2, 32'hFFFF_FFFE);
    rd(4'd2, 32'h0000_00E0, "R4 ctrl keeps 7:5 only");
    wr(4'd2, 32'h0000_0001);
    rd(4'd2, 32'h0, "R3 reload bit reads 0");
    rd(4'd0, 32'h1234_5678, "R3 reload takes seed");

    // normal mode fold, R5
    acc = 32'h1234_5678;
    wr(4'd0, 32'hDEAD_BEEF);
    acc = fold_msb(acc, 32'hDEAD_BEEF, 32'h1EDC_6F41);
    rd(4'd0, acc, "R5 first fold");
    wr(4'd5, 32'h04C1_1DB7);
    wr(4'd0, 32'h0000_0001);
    acc = fold_msb(acc, 32'h0000_0001, 32'h04C1_1DB7);
    rd(4'd0, acc, "R5 second fold");
    rd(4'd0, acc, "R9 repeat read unchanged");

    // same-cycle write and read, R11
    wr_rd(4'd0, 32'hA5A5_0F0F, acc, "R11 read sees old value");
    acc = fold_msb(acc, 32'hA5A5_0F0F, 32'h04C1_1DB7);
    rd(4'd0, acc, "R11 write took effect");

    // unmapped accesses, R10
    wr(4'd1, 32'h0);
    wr(4'd3, 32'h0);
    wr(4'd7, 32'h0);
    rd(4'd3, 32'h0, "R10 unmapped read zero");
    rd(4'd0, acc, "R10 data untouched");
    rd(4'd4, 32'h1234_5678, "R10 seed untouched");
    rd(4'd5, 32'h04C1_1DB7, "R10 poly untouched");

    // input mirror only, R6
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0000_0021);
    wr(4'd0, 32'h0000_00C3);
    rd(4'd0, fold_msb(32'hFFFF_FFFF, flip32(32'h0000_00C3), 32'h04C1_1DB7),
       "R6 input mirrored");

    // output mirror only, R7
    wr(4'd2, 32'h0000_0081);
    wr(4'd0, 32'h0000_00C3);
    rd(4'd0, flip32(fold_msb(32'hFFFF_FFFF, 32'h0000_00C3, 32'h04C1_1DB7)),
       "R7 output mirrored");

    // reflected CRC-32 and CRC-32C, R8
    refl_run(32'h04C1_1DB7, 32'hEDB8_8320, "R8 crc32 reflected");
    refl_run(32'h1EDC_6F41, 32'h82F6_3B78, "R8 crc32c reflected");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule